// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block holds five timer channels that share one register port. Each channel runs a down-counter that advances on a tick. A tick comes from one of two 8-bit prescalers followed by a per-channel power-of-two divider. Software writes a period value and a threshold value into holding buffers. It then raises the channel's load bit, which copies both buffers into the live counter and the live threshold. With repeat mode set, the counter refills from the period buffer each time it runs out, so the waveform repeats.

Channels 0 to 3 each drive a PWM pin. The pin goes high when a decrement lands exactly on the live threshold, and it drops low again when the counter refills. A per-channel polarity bit flips the pin. Channel 4 is a plain countdown timer with no threshold and no pin. Every channel raises a one-clock expiry flag when a decrement brings its counter to zero. A live-count slot for each channel lets software read the running counter.

Top module: `dbuf_pwm_timer`

## Requirements
- R1: After reset every register reads as zero, every PWM pin is low and no expiry flag is raised.
- R2: The tick interval of a channel is (P+1)*2^D clocks. D is the channel's 4-bit field at bits [4c+3:4c] of the divider register (word 1). P is bits [7:0] of the prescale register (word 0) for channels 0 and 1, and bits [15:8] for channels 2 to 4.
- R3: A write to a channel's period buffer or threshold buffer leaves the live counter and the live threshold unchanged. While the channel's load bit is set, the live counter and threshold are held at the buffer values on every clock, and no tick moves the counter.
- R4: Each tick moves a nonzero live counter down by one. The live-count slot (word 5+3c) returns the present counter value.
- R5: The pin goes high on the tick whose decrement yields a value equal to the live threshold. It goes low on a load and on a refill. A threshold equal to the period value therefore never raises the pin.
- R6: With repeat mode set, a tick at zero refills the counter from the period buffer. A period value N then gives an expiry every N+1 ticks.
- R7: With repeat mode clear, the counter stays at zero after it runs out and the channel's run bit reads back as 0.
- R8: The expiry flag is high for exactly one clock, in the cycle after the decrement that reaches zero.
- R9: Setting the polarity bit inverts the pin at once.
- R10: While the run bit is clear and the load bit is clear, the counter does not change.
- R11: Channel 4 has no threshold: its threshold slot (word 16) reads 0 and ignores writes. It has no pin. Its repeat bit sits at control bit 18, its run bit at 16 and its load bit at 17.
- R12: The control register is word 2. For channel c < 4 the bits are: run at 4c, load at 4c+1, polarity at 4c+2, repeat at 4c+3. For channel c, the period buffer is at word 3+3c, the threshold buffer at 4+3c and the live count at 5+3c. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 5 | Word address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed word (combinational) |
| pwmOut | output | 4 | PWM pins of channels 0 to 3 |
| expire | output | 5 | One-clock expiry flags, one per channel |

## Verification
A scoreboard queues expected intervals between expiry flags and checks them for several prescale and divider settings. A design that mixes up the prescaler groups, or that uses a divider of D instead of 2^D, shows the wrong spacing. Duty is counted over whole periods for several thresholds. A threshold equal to the period must give zero high cycles, so a design that tests the match before decrementing gives a visible pulse instead. Further checks watch the live count while the load bit is held and while the run bit is clear, so a design that lets buffer writes or ticks leak into the counter shows a changed value. Channel 4 runs in one-shot mode to confirm that its run bit clears and its count stays at zero.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int DIV_FIELD_W = 4;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic load;     // copy buffers into live registers
    logic tick;     // decrement enable (already gated by run)
    logic run;      // channel running
    logic autoRld;  // refill at zero
    logic invert;   // pin polarity
  } chStrobe_t;
endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 8,
  parameter int PRE_SPLIT = 2,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cntVal,
  input  logic [NUM_CH-1:0]              stopReq,
  output chStrobe_t [NUM_CH-1:0]         strobe,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cntBuf,
  output logic [NUM_CH-2:0][CNT_W-1:0]   cmpBuf
);
  localparam int LAST      = NUM_CH - 1;
  localparam int CTRL_W    = 4 * LAST + 3;
  localparam int DIV_W     = DIV_FIELD_W * NUM_CH;
  localparam int DIV_CNT_W = (1 << DIV_FIELD_W) - 1;
  localparam int SLOT_BASE = 3;
  localparam int ADR_PRE   = 0;
  localparam int ADR_DIV   = 1;
  localparam int ADR_CTRL  = 2;

  function automatic int startBit(int ch);
    return 4 * ch;
  endfunction
  function automatic int updBit(int ch);
    return 4 * ch + 1;
  endfunction
  function automatic int invBit(int ch);
    return 4 * ch + 2;
  endfunction
  function automatic int rldBit(int ch);
    return (ch == LAST) ? 4 * ch + 2 : 4 * ch + 3;
  endfunction

  logic [2*PRE_W-1:0] preCfg;
  logic [DIV_W-1:0]   divCfg;
  logic [CTRL_W-1:0]  ctrlReg;
  logic [1:0]         preTick;
  logic               unusedWr;

  assign unusedWr = ^wrData;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCfg  <= '0;
      divCfg  <= '0;
      ctrlReg <= '0;
      cntBuf  <= '0;
      cmpBuf  <= '0;
    end else begin
      if (wrEn) begin
        if (addr == ADDR_W'(ADR_PRE))  preCfg  <= wrData[2*PRE_W-1:0];
        if (addr == ADDR_W'(ADR_DIV))  divCfg  <= wrData[DIV_W-1:0];
        if (addr == ADDR_W'(ADR_CTRL)) ctrlReg <= wrData[CTRL_W-1:0];
        for (int ch = 0; ch < NUM_CH; ch++) begin
          if (addr == ADDR_W'(SLOT_BASE + 3 * ch)) cntBuf[ch] <= wrData[CNT_W-1:0];
        end
        for (int ch = 0; ch < LAST; ch++) begin
          if (addr == ADDR_W'(SLOT_BASE + 3 * ch + 1)) cmpBuf[ch] <= wrData[CNT_W-1:0];
        end
      end
      // a one-shot expiry clears the run bit; it wins over a same-cycle write
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (stopReq[ch]) ctrlReg[startBit(ch)] <= 1'b0;
      end
    end
  end

  // two shared prescalers
  for (genvar g = 0; g < 2; g++) begin : g_pre
    logic [PRE_W-1:0] preCnt;
    logic [PRE_W-1:0] lim;
    assign lim        = preCfg[g*PRE_W +: PRE_W];
    assign preTick[g] = (preCnt >= lim);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           preCnt <= '0;
      else if (preTick[g]) preCnt <= '0;
      else                 preCnt <= preCnt + 1'b1;
    end
  end

  // per-channel power-of-two divider and strobe packing
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int GRP = (ch < PRE_SPLIT) ? 0 : 1;
    logic [DIV_FIELD_W-1:0] divSel;
    logic [DIV_CNT_W-1:0]   divCnt;
    logic [DIV_CNT_W-1:0]   divMask;
    logic                   chTick;
    logic                   invSel;

    assign divSel  = divCfg[ch*DIV_FIELD_W +: DIV_FIELD_W];
    assign divMask = (DIV_CNT_W'(1) << divSel) - DIV_CNT_W'(1);
    assign chTick  = preTick[GRP] && ((divCnt & divMask) == divMask);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             divCnt <= '0;
      else if (preTick[GRP]) divCnt <= divCnt + 1'b1;
    end

    if (ch == LAST) begin : g_noInv
      assign invSel = 1'b0;
    end else begin : g_inv
      assign invSel = ctrlReg[invBit(ch)];
    end

    assign strobe[ch] = '{
      load:    ctrlReg[updBit(ch)],
      tick:    chTick && ctrlReg[startBit(ch)],
      run:     ctrlReg[startBit(ch)],
      autoRld: ctrlReg[rldBit(ch)],
      invert:  invSel
    };
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADR_PRE))  rdData[2*PRE_W-1:0] = preCfg;
    if (addr == ADDR_W'(ADR_DIV))  rdData[DIV_W-1:0]   = divCfg;
    if (addr == ADDR_W'(ADR_CTRL)) rdData[CTRL_W-1:0]  = ctrlReg;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(SLOT_BASE + 3 * ch))     rdData[CNT_W-1:0] = cntBuf[ch];
      if (addr == ADDR_W'(SLOT_BASE + 3 * ch + 2)) rdData[CNT_W-1:0] = cntVal[ch];
    end
    for (int ch = 0; ch < LAST; ch++) begin
      if (addr == ADDR_W'(SLOT_BASE + 3 * ch + 1)) rdData[CNT_W-1:0] = cmpBuf[ch];
    end
  end
endmodule

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chStrobe_t [NUM_CH-1:0]        strobe,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cntBuf,
  input  logic [NUM_CH-2:0][CNT_W-1:0]  cmpBuf,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  output logic [NUM_CH-1:0]             stopReq,
  output logic [NUM_CH-1:0]             expire,
  output logic [NUM_CH-2:0]             pwmOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chStrobe_t        s;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             expR;

    assign s   = strobe[ch];
    assign nxt = cnt - CNT_W'(1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        expR <= 1'b0;
      end else begin
        expR <= 1'b0;
        if (s.load) begin
          cnt <= cntBuf[ch];
        end else if (s.tick) begin
          if (cnt != '0) begin
            cnt  <= nxt;
            expR <= (nxt == '0);
          end else if (s.autoRld) begin
            cnt <= cntBuf[ch];
          end
        end
      end
    end

    assign stopReq[ch] = s.tick && !s.load && !s.autoRld && (cnt <= CNT_W'(1));
    assign cntVal[ch]  = cnt;
    assign expire[ch]  = expR;

    if (ch < NUM_CH - 1) begin : g_cmp
      logic [CNT_W-1:0] cmp;
      logic             lvl;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cmp <= '0;
          lvl <= 1'b0;
        end else if (s.load) begin
          cmp <= cmpBuf[ch];
          lvl <= 1'b0;
        end else if (s.tick) begin
          if (cnt != '0) begin
            if (nxt == cmp) lvl <= 1'b1;   // match only after a decrement
          end else if (s.autoRld) begin
            lvl <= 1'b0;
          end
        end
      end
      assign pwmOut[ch] = lvl ^ s.invert;
    end else begin : g_noCmp
      logic unusedInv;
      assign unusedInv = s.invert;
    end
  end
endmodule

// File: rtl/dbuf_pwm_timer.sv
module dbuf_pwm_timer
  import pwmt_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 8,
  parameter int PRE_SPLIT = 2,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = $clog2(3 + 3 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-2:0] pwmOut,
  output logic [NUM_CH-1:0] expire
);
  chStrobe_t [NUM_CH-1:0]        strobe;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntBuf;
  logic [NUM_CH-2:0][CNT_W-1:0]  cmpBuf;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntVal;
  logic [NUM_CH-1:0]             stopReq;

  pwmt_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .PRE_SPLIT(PRE_SPLIT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cntVal(cntVal), .stopReq(stopReq),
    .strobe(strobe), .cntBuf(cntBuf), .cmpBuf(cmpBuf)
  );

  pwmt_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntBuf(cntBuf), .cmpBuf(cmpBuf),
    .cntVal(cntVal), .stopReq(stopReq), .expire(expire), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input chStrobe_t [NUM_CH-1:0]        strobe,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntBuf,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  input logic [NUM_CH-1:0]             expire,
  input logic [NUM_CH-2:0]             pwmOut
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_load_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobe[c].load |=> cntVal[c] == $past(cntBuf[c]));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[c].tick && !strobe[c].load && cntVal[c] != '0)
        |=> cntVal[c] == $past(cntVal[c]) - CNT_W'(1));

    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && !strobe[c].autoRld) |-> !strobe[c].run);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] |=> !expire[c]);

    p_expire_at_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] |-> cntVal[c] == '0);

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[c].run && !strobe[c].load) |=> $stable(cntVal[c]));

    if (c < NUM_CH - 1) begin : g_pin
      p_load_low_r5: assert property (@(posedge clk) disable iff (!rstN)
        strobe[c].load |=> pwmOut[c] == strobe[c].invert);
    end
  end
endmodule

bind dbuf_pwm_timer pwmt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_pwmtChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .cntBuf(cntBuf),
  .cntVal(cntVal), .expire(expire), .pwmOut(pwmOut)
);

// File: tb/test_dbuf_pwm_timer.sv
`timescale 1ns/1ps
module test_dbuf_pwm_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  pwmOut;
  logic [4:0]  expire;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct { int ch; int interval; string req; } sbItem_t;
  sbItem_t sbQ[$];
  int sbCh = -1;
  int lastStamp = 0;
  bit haveStamp = 1'b0;

  always #2 clk = ~clk;

  dbuf_pwm_timer i_dbuf_pwm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut), .expire(expire)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    addr = 5'(a);
    #1 v = rdData;
  endtask

  function automatic logic [31:0] cb(int ch, bit st, bit up, bit iv, bit rl);
    logic [31:0] v;
    v = '0;
    if (ch == 4) begin
      v[16] = st; v[17] = up; v[18] = rl;
    end else begin
      v[4*ch] = st; v[4*ch+1] = up; v[4*ch+2] = iv; v[4*ch+3] = rl;
    end
    return v;
  endfunction

  task automatic countHigh(int ch, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += int'(pwmOut[ch]);
    end
  endtask

  // scoreboard driver: queue expected expiry spacings for one channel
  task automatic expectPeriod(int ch, int interval, int n, string req);
    haveStamp = 1'b0;
    for (int i = 0; i < n; i++) sbQ.push_back('{ch, interval, req});
    sbCh = ch;
    while (sbQ.size() != 0) @(negedge clk);
    sbCh = -1;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (sbCh >= 0 && expire[sbCh]) begin
        if (haveStamp && sbQ.size() > 0) begin
          sbItem_t it;
          it = sbQ.pop_front();
          chk(it.req, cyc - lastStamp, it.interval);
        end
        lastStamp = cyc;
        haveStamp = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, v2;
    int h, seen;
    logic pinHold;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 pins", 32'(pwmOut), 0);
    chk("R1 expire", 32'(expire), 0);
    rd(2, v);  chk("R1 control", v, 0);
    rd(5, v);  chk("R1 live count ch0", v, 0);

    // R12 / R3: buffers read back, live count untouched
    wr(3, 5); wr(4, 2);
    rd(3, v);  chk("R12 period buffer ch0", v, 5);
    rd(4, v);  chk("R12 threshold buffer ch0", v, 2);
    rd(5, v);  chk("R3 live count before load", v, 0);

    wr(2, cb(0, 0, 1, 0, 0));
    rd(5, v);  chk("R3 load copies period", v, 5);
    rd(2, v);  chk("R12 control readback", v, cb(0, 0, 1, 0, 0));

    // start in repeat mode
    wr(2, cb(0, 1, 0, 0, 1));
    rd(5, v); rd(5, v2);
    chk("R4 live count steps down", v2, (v == 0) ? 5 : v - 1);
    countHigh(0, 12, h); chk("R5 duty threshold 2 of period 5", h, 6);
    expectPeriod(0, 6, 2, "R6 repeat period N+1 ticks");

    // R3: threshold buffer write without load has no effect
    wr(4, 5);
    countHigh(0, 12, h); chk("R3 threshold buffer isolated", h, 6);

    // R5: threshold equal to period never raises the pin; R3 hold while load set
    wr(2, cb(0, 1, 1, 0, 1));
    rd(5, v); chk("R3 load held", v, 5);
    repeat (3) @(negedge clk);
    rd(5, v); chk("R3 load held over ticks", v, 5);
    wr(2, cb(0, 1, 0, 0, 1));
    countHigh(0, 12, h); chk("R5 threshold equals period", h, 0);

    // threshold 1 then polarity
    wr(4, 1);
    wr(2, cb(0, 1, 1, 0, 1));
    wr(2, cb(0, 1, 0, 0, 1));
    countHigh(0, 12, h); chk("R5 duty threshold 1", h, 4);
    wr(2, cb(0, 1, 0, 1, 1));
    countHigh(0, 12, h); chk("R9 inverted duty", h, 8);

    // R10: freeze
    wr(2, cb(0, 0, 0, 1, 1));
    rd(5, v); pinHold = pwmOut[0];
    repeat (5) @(negedge clk);
    rd(5, v2); chk("R10 frozen count", v2, v);
    chk("R10 frozen pin", 32'(pwmOut[0]), 32'(pinHold));

    // R2: prescaler groups and dividers
    wr(0, (32'd2 << 8) | 32'd1);
    wr(1, (32'd1 << 8) | 32'd2);
    rd(0, v); chk("R12 prescale readback", v, 32'h0201);
    wr(2, cb(0, 0, 1, 0, 1));
    wr(2, cb(0, 1, 0, 0, 1));
    expectPeriod(0, 6 * 2 * 4, 2, "R2 group A prescale 1 divider 4");
    wr(9, 3); wr(10, 0);
    wr(2, cb(2, 0, 1, 0, 1));
    wr(2, cb(2, 1, 0, 0, 1));
    expectPeriod(2, 4 * 3 * 2, 2, "R2 group B prescale 2 divider 2");

    // R11 / R7 / R8: last channel one-shot
    wr(2, 0);
    wr(16, 7);
    rd(16, v); chk("R11 no threshold slot", v, 0);
    wr(15, 3);
    wr(2, cb(4, 0, 1, 0, 0));
    rd(17, v); chk("R11 last channel load", v, 3);
    wr(2, cb(4, 1, 0, 0, 0));
    seen = 0;
    for (int i = 0; i < 200 && seen == 0; i++) begin
      @(negedge clk);
      if (expire[4]) seen = 1;
    end
    chk("R8 one-shot expiry seen", seen, 1);
    @(negedge clk);
    chk("R8 expiry one clock", 32'(expire[4]), 0);
    rd(2, v); chk("R7 run bit cleared", 32'(v[16]), 0);
    rd(17, v); chk("R7 count stays zero", v, 0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (expire[4]) seen++;
    end
    chk("R7 no further expiry", seen, 0);

    // R11: separate repeat bit for last channel
    wr(15, 2);
    wr(2, cb(4, 0, 1, 0, 1));
    wr(2, cb(4, 1, 0, 0, 1));
    expectPeriod(4, 3 * 3, 2, "R11 last channel repeat bit");

    finishRun();
  end
endmodule